// File: doc/BRIEF.md
# Command Packet Transmit Assembler

This block builds short and long command packets for a serial display link from register-bus writes and sends them out one byte at a time. Software loads the payload of a long packet as 32-bit words into a payload FIFO. It then writes a header word, and that write launches the packet. The header's two data bytes act in one of two ways. In a short packet they are the two parameters. In a long packet they are the payload byte count, low byte first.

The block sends the four header bytes on a valid/ready byte port, with a zero placeholder in place of the error-correction byte. For a long packet it then sends exactly the counted number of payload bytes, taken least-significant byte first from each FIFO word, and ends with two zero checksum placeholder bytes. A header written while a packet is still in flight waits in a one-entry queue.

When a long packet completes and the payload FIFO is empty, the block raises an interrupt source flag. Software clears that flag by writing a one to it, and can mask it separately.

Top module: `cmdPktTx`

## Requirements
- R1: After reset, txValid, txLast, fifoFull, fifoOvfErr, hdrOvfErr, irqSrc and irqOut are 0 and fifoEmpty is 1.
- R2: A write to bus address 0 is a header: bits 5:0 are the data type, bits 15:8 the first data byte, bits 23:16 the second. The packet is long when data-type bits 3:0 equal 9, C, D or E, and short otherwise. A short packet is sent as four bytes: {2'b00, type}, first data byte, second data byte, 8'h00. txLast is high on the fourth byte. Header bits 7:6 do not reach the output.
- R3: A long packet sends its four header bytes, then N payload bytes, then two 8'h00 bytes, with txLast on the final byte. N is {second data byte, first data byte}. The payload comes from words written to bus address 1, and bits 7:0 of each word are sent first.
- R4: Payload bytes left over in the last FIFO word of a long packet are discarded. The next long packet starts from the next FIFO word.
- R5: A long packet with N = 0 sends only its header and the two checksum bytes, and removes no word from the FIFO.
- R6: While txValid is high and txReady is low, txValid stays high and txData holds its value.
- R7: The payload FIFO holds 16 words, and fifoFull is 1 when all 16 are in use. A payload write while the FIFO is full is dropped and sets fifoOvfErr, which stays set until reset.
- R8: A header written while a packet is being sent is queued and sent, in order, right after that packet.
- R9: A header write while the queue already holds a header that is not being taken in that cycle is dropped and sets hdrOvfErr, which stays set until reset.
- R10: irqSrc (interrupt source bit 29) is set when the final byte of a long packet is accepted while the FIFO is empty. It is not set if the FIFO still holds words at that point.
- R11: A write to bus address 2 with bit 29 set clears irqSrc. The same write with bit 29 clear leaves it unchanged.
- R12: irqOut equals irqSrc AND NOT the mask bit, which is bit 29 of the word written to bus address 3 (reset value 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Word address: 0 header, 1 payload, 2 interrupt source, 3 interrupt mask |
| busWrData | input | 32 | Write data |
| txValid | output | 1 | Output byte valid |
| txData | output | 8 | Output byte |
| txLast | output | 1 | Current byte is the last of its packet |
| txReady | input | 1 | Sink accepts the byte this cycle |
| fifoFull | output | 1 | Payload FIFO full |
| fifoEmpty | output | 1 | Payload FIFO empty |
| fifoOvfErr | output | 1 | Sticky: payload write dropped on full FIFO |
| hdrOvfErr | output | 1 | Sticky: header write dropped on full queue |
| irqSrc | output | 1 | Payload-drained interrupt source (bit 29) |
| irqOut | output | 1 | Unmasked interrupt request |

## Verification
The stimulus has four kinds of packet:
- Short packets. These show that the header's data bytes pass through unchanged as parameters, and that the unused header bits are dropped.
- Long packets whose byte counts are a multiple of four, or leave one, two or three bytes in the last word. These separate exact byte counting from whole-word draining, and show that leftover bytes are discarded and not carried into the next packet.
- A zero-length long packet placed ahead of a FIFO that already holds data. This shows that a long packet pops no word when it has no payload.
- Back-to-back headers sent while the sink is stalled, and a FIFO filled past its depth. These separate queueing from overflow.

The interrupt flag is checked after packets that leave the FIFO empty and after packets that leave words behind. The mask and the write-one-to-clear path are then exercised on it separately.

// File: rtl/cmdPktTx_pkg.sv
package cmdPktTx_pkg;

  localparam int WORD_W      = 32;
  localparam int LANES       = WORD_W / 8;
  localparam int LANE_W      = $clog2(LANES);
  localparam int TYPE_W      = 6;
  localparam int WC_W        = 16;
  localparam int HDR_BYTES   = 4;
  localparam int CSUM_BYTES  = 2;
  localparam int IRQ_BIT     = 29;

  // bus word addresses
  localparam int REG_HDR     = 0;
  localparam int REG_PAYLOAD = 1;
  localparam int REG_IRQSRC  = 2;
  localparam int REG_IRQMSK  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_FETCH,
    ST_PAY,
    ST_CSUM
  } engState_e;

  typedef enum logic [1:0] {
    SRC_HDR,
    SRC_WORD,
    SRC_ZERO
  } byteSrc_e;

  typedef struct packed {
    logic [WC_W-1:0]   params;    // [7:0] first data byte, [15:8] second
    logic [TYPE_W-1:0] dataType;
  } pktHdr_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              loadHdr;
    logic              popWord;
    byteSrc_e          byteSrc;
    logic [LANE_W-1:0] lane;
    logic              pktDone;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic            hdrQValid;
    logic            isLong;
    logic [WC_W-1:0] wordCount;
    logic            fifoEmpty;
  } dpStatus_t;

  function automatic logic isLongType(input logic [TYPE_W-1:0] dt);
    return (dt[3:0] == 4'h9) || (dt[3:0] == 4'hC) ||
           (dt[3:0] == 4'hD) || (dt[3:0] == 4'hE);
  endfunction

endpackage

// File: rtl/pyldFifo.sv
module pyldFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pushOk, popOk;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign pushOk  = push && !full;
  assign popOk   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (popOk)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({pushOk, popOk})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cmdPktTxData.sv
module cmdPktTxData
  import cmdPktTx_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic [7:0]        txData,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              fifoOvfErr,
  output logic              hdrOvfErr,
  output logic              irqSrc,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] ADR_HDR = ADDR_W'(REG_HDR);
  localparam logic [ADDR_W-1:0] ADR_PAY = ADDR_W'(REG_PAYLOAD);
  localparam logic [ADDR_W-1:0] ADR_SRC = ADDR_W'(REG_IRQSRC);
  localparam logic [ADDR_W-1:0] ADR_MSK = ADDR_W'(REG_IRQMSK);

  logic              hdrWr, payWr, srcWr, mskWr;
  pktHdr_t           hdrQ, curHdr, hdrIn;
  logic              hdrQValid;
  logic [WORD_W-1:0] fifoOut, wordReg;
  logic              irqMask;
  logic [7:0]        wordBytes [LANES];
  logic [7:0]        hdrBytes  [HDR_BYTES];

  assign hdrWr = busWrEn && (busAddr == ADR_HDR);
  assign payWr = busWrEn && (busAddr == ADR_PAY);
  assign srcWr = busWrEn && (busAddr == ADR_SRC);
  assign mskWr = busWrEn && (busAddr == ADR_MSK);

  assign hdrIn = '{params: busWrData[23:8], dataType: busWrData[TYPE_W-1:0]};

  pyldFifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (payWr),
    .pushData (busWrData),
    .pop      (strobe.popWord),
    .popData  (fifoOut),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  // header queue and active header
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ      <= '0;
      hdrQValid <= 1'b0;
      curHdr    <= '0;
    end else begin
      if (hdrWr && (!hdrQValid || strobe.loadHdr)) begin
        hdrQ      <= hdrIn;
        hdrQValid <= 1'b1;
      end else if (strobe.loadHdr) begin
        hdrQValid <= 1'b0;
      end
      if (strobe.loadHdr) curHdr <= hdrQ;
    end
  end

  // payload word holding register
  always_ff @(posedge clk) begin
    if (!rstN)               wordReg <= '0;
    else if (strobe.popWord) wordReg <= fifoOut;
  end

  // sticky error flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoOvfErr <= 1'b0;
      hdrOvfErr  <= 1'b0;
    end else begin
      if (payWr && fifoFull)                         fifoOvfErr <= 1'b1;
      if (hdrWr && hdrQValid && !strobe.loadHdr)     hdrOvfErr  <= 1'b1;
    end
  end

  // interrupt source (set wins over clear) and mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqSrc  <= 1'b0;
      irqMask <= 1'b0;
    end else begin
      irqSrc <= (irqSrc && !(srcWr && busWrData[IRQ_BIT])) ||
                (strobe.pktDone && fifoEmpty);
      if (mskWr) irqMask <= busWrData[IRQ_BIT];
    end
  end

  assign irqOut = irqSrc && !irqMask;

  // byte lanes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wordBytes[g] = wordReg[g*8 +: 8];
  end

  assign hdrBytes[0] = {{(8 - TYPE_W){1'b0}}, curHdr.dataType};
  for (genvar g = 1; g < HDR_BYTES - 1; g++) begin : g_hdrByte
    assign hdrBytes[g] = curHdr.params[(g-1)*8 +: 8];
  end
  assign hdrBytes[HDR_BYTES-1] = 8'h00;  // ECC placeholder

  always_comb begin
    case (strobe.byteSrc)
      SRC_HDR:  txData = hdrBytes[strobe.lane];
      SRC_WORD: txData = wordBytes[strobe.lane];
      default:  txData = 8'h00;
    endcase
  end

  assign status.hdrQValid = hdrQValid;
  assign status.isLong    = isLongType(curHdr.dataType);
  assign status.wordCount = curHdr.params;
  assign status.fifoEmpty = fifoEmpty;

endmodule

// File: rtl/cmdPktTxCtrl.sv
module cmdPktTxCtrl
  import cmdPktTx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic        txReady,
  output ctrlStrobe_t strobe,
  output logic        txValid,
  output logic        txLast
);

  engState_e         state, stateN;
  logic [LANE_W-1:0] idx, idxN;
  logic [WC_W-1:0]   remain, remainN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      remain <= '0;
    end else begin
      state  <= stateN;
      idx    <= idxN;
      remain <= remainN;
    end
  end

  always_comb begin
    stateN         = state;
    idxN           = idx;
    remainN        = remain;
    strobe         = '0;
    strobe.byteSrc = SRC_ZERO;
    strobe.lane    = idx;
    txValid        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (status.hdrQValid) begin
          strobe.loadHdr = 1'b1;
          stateN         = ST_HDR;
          idxN           = '0;
        end
      end
      ST_HDR: begin
        txValid        = 1'b1;
        strobe.byteSrc = SRC_HDR;
        if (txReady) begin
          if (idx == LANE_W'(HDR_BYTES - 1)) begin
            idxN = '0;
            if (!status.isLong) begin
              stateN = ST_IDLE;
            end else begin
              remainN = status.wordCount;
              stateN  = (status.wordCount == '0) ? ST_CSUM : ST_FETCH;
            end
          end else begin
            idxN = idx + LANE_W'(1);
          end
        end
      end
      ST_FETCH: begin
        if (!status.fifoEmpty) begin
          strobe.popWord = 1'b1;
          stateN         = ST_PAY;
          idxN           = '0;
        end
      end
      ST_PAY: begin
        txValid        = 1'b1;
        strobe.byteSrc = SRC_WORD;
        if (txReady) begin
          remainN = remain - WC_W'(1);
          if (remain == WC_W'(1)) begin
            stateN = ST_CSUM;
            idxN   = '0;
          end else if (idx == LANE_W'(LANES - 1)) begin
            stateN = ST_FETCH;
          end else begin
            idxN = idx + LANE_W'(1);
          end
        end
      end
      ST_CSUM: begin
        txValid = 1'b1;
        if (txReady) begin
          if (idx == LANE_W'(CSUM_BYTES - 1)) begin
            strobe.pktDone = 1'b1;
            stateN         = ST_IDLE;
            idxN           = '0;
          end else begin
            idxN = idx + LANE_W'(1);
          end
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  assign txLast = ((state == ST_HDR) && (idx == LANE_W'(HDR_BYTES - 1)) && !status.isLong) ||
                  ((state == ST_CSUM) && (idx == LANE_W'(CSUM_BYTES - 1)));

endmodule

// File: rtl/cmdPktTx.sv
module cmdPktTx
  import cmdPktTx_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              txReady,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              fifoOvfErr,
  output logic              hdrOvfErr,
  output logic              irqSrc,
  output logic              irqOut
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  cmdPktTxCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .status  (status),
    .txReady (txReady),
    .strobe  (strobe),
    .txValid (txValid),
    .txLast  (txLast)
  );

  cmdPktTxData #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .strobe     (strobe),
    .status     (status),
    .txData     (txData),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .fifoOvfErr (fifoOvfErr),
    .hdrOvfErr  (hdrOvfErr),
    .irqSrc     (irqSrc),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/cmdPktTx_chk.sv
module cmdPktTx_chk
  import cmdPktTx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              clrBit,
  input logic              txValid,
  input logic [7:0]        txData,
  input logic              txLast,
  input logic              txReady,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic              fifoOvfErr,
  input logic              hdrOvfErr,
  input logic              irqSrc,
  input logic              irqOut
);

  localparam logic [ADDR_W-1:0] ADR_HDR = ADDR_W'(REG_HDR);
  localparam logic [ADDR_W-1:0] ADR_SRC = ADDR_W'(REG_IRQSRC);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast)); // R6

  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R3

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoOvfErr) |-> $past(fifoFull)); // R7

  AST_FIFO_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fifoOvfErr |=> fifoOvfErr); // R7

  AST_HDR_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hdrOvfErr) |-> $past(busWrEn && (busAddr == ADR_HDR))); // R9

  AST_HDR_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hdrOvfErr |=> hdrOvfErr); // R9

  AST_IRQ_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqSrc) |-> $past(busWrEn && (busAddr == ADR_SRC) && clrBit)); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqSrc); // R12

endmodule

bind cmdPktTx cmdPktTx_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .clrBit     (busWrData[cmdPktTx_pkg::IRQ_BIT]),
  .txValid    (txValid),
  .txData     (txData),
  .txLast     (txLast),
  .txReady    (txReady),
  .fifoFull   (fifoFull),
  .fifoEmpty  (fifoEmpty),
  .fifoOvfErr (fifoOvfErr),
  .hdrOvfErr  (hdrOvfErr),
  .irqSrc     (irqSrc),
  .irqOut     (irqOut)
);

// File: tb/cmdPktTx_tb_top.sv
module cmdPktTx_tb_top;

  localparam int ADDR_W   = 4;
  localparam int NVEC     = 6;
  localparam int WD_LIMIT = 100000;

  // vector table: header word and sink-ready pattern (0 always, 1 periodic stall)
  localparam logic [31:0] VEC_HDR [NVEC] = '{
    32'h0000_11C5,   // short, bits 7:6 set (R2)
    32'h0048_3615,   // short, two params (R2)
    32'h0000_0839,   // long, 8 bytes (R3)
    32'h0000_0529,   // long, 5 bytes (R3, R4)
    32'h0000_0739,   // long, 7 bytes, stalled sink (R6)
    32'h0000_033E    // long, 3 bytes, stalled sink (R6)
  };
  localparam logic [1:0] VEC_RDY [NVEC] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic              txValid, txLast, txReady;
  logic [7:0]        txData;
  logic              fifoFull, fifoEmpty, fifoOvfErr, hdrOvfErr, irqSrc, irqOut;

  logic       txReadyR = 1'b1;
  logic [1:0] readyMode = 2'd0;
  int         stallCnt = 0;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;
  logic [8:0] expQ[$];
  logic [8:0] gotQ[$];

  assign txReady = txReadyR;

  always #2.5 clk = ~clk;

  cmdPktTx #(.ADDR_W(ADDR_W), .FIFO_DEPTH(16)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .txValid    (txValid),
    .txData     (txData),
    .txLast     (txLast),
    .txReady    (txReady),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .fifoOvfErr (fifoOvfErr),
    .hdrOvfErr  (hdrOvfErr),
    .irqSrc     (irqSrc),
    .irqOut     (irqOut)
  );

  // sink: pick ready for the next edge, then record the beat that edge takes
  always @(negedge clk) begin
    logic rdy;
    case (readyMode)
      2'd0:    rdy = 1'b1;
      2'd1:    rdy = (stallCnt % 3) != 2;
      default: rdy = 1'b0;
    endcase
    stallCnt = stallCnt + 1;
    txReadyR = rdy;
    if (rstN && txValid && rdy) gotQ.push_back({txLast, txData});
  end

  function automatic logic [7:0] payByte(input int k, input int i);
    return 8'((k * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    busWrEn   = 1'b1;
    busAddr   = ADDR_W'(addr);
    busWrData = data;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expHeader(input logic [31:0] hdr, input bit isShort);
    expQ.push_back({1'b0, 2'b00, hdr[5:0]});
    expQ.push_back({1'b0, hdr[15:8]});
    expQ.push_back({1'b0, hdr[23:16]});
    expQ.push_back({isShort, 8'h00});
  endtask

  task automatic expCsum();
    expQ.push_back({1'b0, 8'h00});
    expQ.push_back({1'b1, 8'h00});
  endtask

  // write payload words for a long packet built from payByte(k, *)
  task automatic loadPayload(input int k, input int wc);
    for (int w = 0; w < (wc + 3) / 4; w++) begin
      logic [31:0] word = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < wc) word[b*8 +: 8] = payByte(k, w * 4 + b);
      busWrite(1, word);
    end
  endtask

  task automatic expPayload(input int k, input int first, input int n);
    for (int i = first; i < first + n; i++) expQ.push_back({1'b0, payByte(k, i)});
  endtask

  task automatic checkPkt(input string req);
    int waited = 0;
    while (gotQ.size() < expQ.size() && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    idle(20);
    total++;
    if (gotQ.size() != expQ.size()) begin
      bad++;
      $display("FAIL %s byte count: actual=%0d expected=%0d", req, gotQ.size(), expQ.size());
    end else begin
      int firstBad = -1;
      for (int i = 0; i < expQ.size(); i++)
        if (gotQ[i] !== expQ[i] && firstBad < 0) firstBad = i;
      if (firstBad >= 0) begin
        bad++;
        $display("FAIL %s byte %0d: actual=%0h expected=%0h", req, firstBad,
                 gotQ[firstBad], expQ[firstBad]);
      end
    end
    expQ.delete();
    gotQ.delete();
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    chk(!txValid && !txLast && !fifoFull && fifoEmpty && !fifoOvfErr && !hdrOvfErr
        && !irqSrc && !irqOut, "R1", "reset outputs",
        {txValid, txLast, fifoFull, fifoEmpty, fifoOvfErr, hdrOvfErr, irqSrc, irqOut},
        8'b0001_0000);

    // vector table: R2 short packets, R3/R4 long packets, R6 under stalls
    for (int k = 0; k < NVEC; k++) begin
      logic [31:0] hdr = VEC_HDR[k];
      bit isShort = !(hdr[3:0] inside {4'h9, 4'hC, 4'hD, 4'hE});
      int wc = int'(hdr[23:8]);
      readyMode = VEC_RDY[k];
      expHeader(hdr, isShort);
      if (!isShort) begin
        loadPayload(k, wc);
        expPayload(k, 0, wc);
        expCsum();
      end
      busWrite(0, hdr);
      checkPkt(isShort ? "R2" : (readyMode != 0 ? "R6" : "R3"));
    end
    readyMode = 2'd0;

    // R11 / R10 / R12 interrupt source behaviour
    busWrite(2, 32'h2000_0000);
    idle(1);
    chk(!irqSrc, "R11", "clear by writing one", irqSrc, 0);
    loadPayload(7, 8);
    expHeader(32'h0000_0429, 1'b0); expPayload(7, 0, 4); expCsum();
    busWrite(0, 32'h0000_0429);
    checkPkt("R10");
    chk(!irqSrc, "R10", "no set with FIFO non-empty", irqSrc, 0);
    expHeader(32'h0000_0429, 1'b0); expPayload(7, 4, 4); expCsum();
    busWrite(0, 32'h0000_0429);
    checkPkt("R10");
    chk(irqSrc, "R10", "set on drain", irqSrc, 1);
    chk(irqOut, "R12", "unmasked output", irqOut, 1);
    busWrite(3, 32'h2000_0000);
    idle(1);
    chk(!irqOut && irqSrc, "R12", "masked output", {irqOut, irqSrc}, 2'b01);
    busWrite(2, 32'hDFFF_FFFF);
    idle(1);
    chk(irqSrc, "R11", "zero in bit 29 keeps flag", irqSrc, 1);
    busWrite(2, 32'h2000_0000);
    idle(1);
    chk(!irqSrc, "R11", "one in bit 29 clears flag", irqSrc, 0);
    busWrite(3, 32'h0000_0000);

    // R5 zero-length long packet leaves FIFO untouched
    loadPayload(8, 4);
    expHeader(32'h0000_0029, 1'b0); expCsum();
    busWrite(0, 32'h0000_0029);
    checkPkt("R5");
    chk(!fifoEmpty, "R5", "FIFO word kept", fifoEmpty, 0);
    expHeader(32'h0000_0439, 1'b0); expPayload(8, 0, 4); expCsum();
    busWrite(0, 32'h0000_0439);
    checkPkt("R5");

    // R4 leftover bytes dropped
    busWrite(1, 32'hDDCC_BBAA);
    busWrite(1, 32'h4433_2211);
    expHeader(32'h0000_0529, 1'b0);
    expQ.push_back(9'h0AA); expQ.push_back(9'h0BB); expQ.push_back(9'h0CC);
    expQ.push_back(9'h0DD); expQ.push_back(9'h011);
    expCsum();
    busWrite(0, 32'h0000_0529);
    checkPkt("R4");
    busWrite(1, 32'h8877_6655);
    expHeader(32'h0000_0429, 1'b0);
    expQ.push_back(9'h055); expQ.push_back(9'h066); expQ.push_back(9'h077);
    expQ.push_back(9'h088);
    expCsum();
    busWrite(0, 32'h0000_0429);
    checkPkt("R4");

    // R8 / R9 header queue under a fully stalled sink
    readyMode = 2'd2;
    busWrite(0, 32'h0000_2205);
    idle(3);
    busWrite(0, 32'h0000_4415);
    idle(1);
    chk(!hdrOvfErr, "R9", "one queued header is no error", hdrOvfErr, 0);
    busWrite(0, 32'h0000_6605);
    idle(1);
    chk(hdrOvfErr, "R9", "third header flags overflow", hdrOvfErr, 1);
    expHeader(32'h0000_2205, 1'b1);
    expHeader(32'h0000_4415, 1'b1);
    readyMode = 2'd0;
    checkPkt("R8");

    // R7 FIFO depth and overflow
    for (int w = 0; w < 16; w++)
      busWrite(1, {payByte(9, w*4+3), payByte(9, w*4+2), payByte(9, w*4+1), payByte(9, w*4)});
    idle(1);
    chk(fifoFull && !fifoOvfErr, "R7", "full at 16 words", {fifoFull, fifoOvfErr}, 2'b10);
    busWrite(1, 32'hDEAD_BEEF);
    idle(1);
    chk(fifoFull && fifoOvfErr, "R7", "write on full flagged", {fifoFull, fifoOvfErr}, 2'b11);
    expHeader(32'h0000_4039, 1'b0); expPayload(9, 0, 64); expCsum();
    busWrite(0, 32'h0000_4039);
    checkPkt("R7");
    chk(fifoEmpty && irqSrc && fifoOvfErr, "R7", "drained, error sticky",
        {fifoEmpty, irqSrc, fifoOvfErr}, 3'b111);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule